// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs one memory or I/O transfer at a time over an external bus whose lower lines carry both address and data. An internal requester presents an address, a direction flag, a memory/IO flag, an upper-byte enable, a status word and write data on a valid/accept handshake. The sequencer then steps through four clock states (T1, T2, T3, T4). It inserts wait states after T3 for as long as the target holds its ready line low.

In the first state the full address goes out on every bus line, and an address strobe pulses so that an external latch can capture the address on the strobe's falling edge. From the second state on, the upper lines carry the status word in place of the address. The lower lines carry write data, or they are released so that the target can drive read data. A direction line and an active-low enable steer an external transceiver. Read data is captured from the bus on the edge that enters T4, and T4 is flagged with a one-cycle done pulse. When a new request is waiting in T4, the next cycle starts with T1 on the very next clock.

Top module: `bus_cycle_seq`

## Requirements
- R1: With the ready line high when T3 ends, a transfer lasts exactly four cycles: strobe pulse in T1, read or write strobe low in T2 and T3 only, and done high in T4.
- R2: In T1, addr_strobe is 1, mux_out equals the full request address with both output enables at 1, hi_byte_n equals the inverted byte-high flag, space_mem equals the memory flag, and both data strobes are high.
- R3: xcvr_dir_tx is 1 for a write and 0 for a read, from T1 through T4. xcvr_en_n is high in idle, T1 and T4, and low in T2, T3 and every wait state.
- R4: In T2 of a read, rd_stb_n goes low, mux_oe_lo goes to 0 (lower lines released) and xcvr_en_n goes low.
- R5: In a write, wr_stb_n is low from T2 through the last T3 or wait state, and the lower DATA_W lines of mux_out carry the write data with mux_oe_lo at 1 for that whole span.
- R6: From T2 through T4, the upper ADDR_W-DATA_W lines of mux_out carry the request status word with mux_oe_hi at 1, and hi_byte_n is 1.
- R7: bus_rdy is sampled on the edge that ends T3 and on the edge that ends each wait state. Each low sample adds one wait state whose outputs equal those of T3. The level of bus_rdy in any other state has no effect.
- R8: In T4, both data strobes are high, xcvr_en_n is high, mux_oe_lo is 0 and rsp_done is 1 for exactly that cycle. After a read, rsp_rdata equals the value on mux_in at the edge that entered T4.
- R9: In idle, addr_strobe is 0, both strobes are high, both output enables are 0 and rsp_done is 0.
- R10: req_ready is 1 in idle and in T4 only. A request accepted in T4 produces T1 in the very next cycle.
- R11: While reset is asserted, and after it is released, the block is idle with xcvr_dir_tx 0 and rsp_rdata 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_addr | input | ADDR_W | Transfer address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory space, 0 = I/O space |
| req_bhe | input | 1 | Upper byte enable |
| req_stat | input | ADDR_W-DATA_W | Status word for the upper lines after T1 |
| req_wdata | input | DATA_W | Write data |
| bus_rdy | input | 1 | Target ready, sampled at the end of T3 and each wait state |
| addr_strobe | output | 1 | Address latch strobe, high in T1 |
| rd_stb_n | output | 1 | Read strobe, active low |
| wr_stb_n | output | 1 | Write strobe, active low |
| xcvr_en_n | output | 1 | Transceiver enable, active low |
| xcvr_dir_tx | output | 1 | Transceiver direction, 1 = outbound |
| space_mem | output | 1 | 1 = memory, 0 = I/O |
| hi_byte_n | output | 1 | Upper byte enable in T1, status bit after that |
| mux_out | output | ADDR_W | Value driven onto the bus lines |
| mux_oe_lo | output | 1 | Output enable of the lower DATA_W lines |
| mux_oe_hi | output | 1 | Output enable of the upper lines |
| mux_in | input | DATA_W | Lower bus lines as seen from the bus |
| rsp_done | output | 1 | High in T4 |
| rsp_rdata | output | DATA_W | Data captured by the last read |

## Verification
The bench builds the block with its defaults: ADDR_W of 20 and DATA_W of 16. That gives a four-line status field above a sixteen-line shared field, so a stray address or data bit leaking into either part shows up as a separate mismatch. The reset synchronizer has two stages, which keeps the release delay short. Random transfers draw zero to three wait states, and about half of them are chained to the next request in T4. Read data is changed in every cycle before the capture edge, which exposes capture on the wrong edge. The ready line is also toggled in T2, where it must have no effect.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_TW   = 3'd4,
    ST_T4   = 3'd5
  } bcs_state_e;
endpackage

// File: rtl/bcs_rst_sync.sv
module bcs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) q <= 1'b0;
        else         q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) q <= '0;
        else         q <= {q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n = q[STAGES-1];
endmodule

// File: rtl/bcs_fsm.sv
module bcs_fsm
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int ST_W   = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_mem,
  input  logic              req_bhe,
  input  logic [ST_W-1:0]   req_stat,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              bus_rdy,
  output bcs_state_e        state,
  output logic              last_edge,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              cur_write,
  output logic              cur_mem,
  output logic              cur_bhe,
  output logic [ST_W-1:0]   cur_stat,
  output logic [DATA_W-1:0] cur_wdata
);
  bcs_state_e state_nx;
  logic       accept;

  assign req_ready = (state == ST_IDLE) || (state == ST_T4);
  assign accept    = req_valid && req_ready;
  assign last_edge = ((state == ST_T3) || (state == ST_TW)) && bus_rdy;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: state_nx = accept ? ST_T1 : ST_IDLE;
      ST_T1:   state_nx = ST_T2;
      ST_T2:   state_nx = ST_T3;
      ST_T3,
      ST_TW:   state_nx = bus_rdy ? ST_T4 : ST_TW;
      ST_T4:   state_nx = accept ? ST_T1 : ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr  <= '0;
      cur_write <= 1'b0;
      cur_mem   <= 1'b0;
      cur_bhe   <= 1'b0;
      cur_stat  <= '0;
      cur_wdata <= '0;
    end else if (accept) begin
      cur_addr  <= req_addr;
      cur_write <= req_write;
      cur_mem   <= req_mem;
      cur_bhe   <= req_bhe;
      cur_stat  <= req_stat;
      cur_wdata <= req_wdata;
    end
  end
endmodule

// File: rtl/bcs_drive.sv
module bcs_drive
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int ST_W   = ADDR_W - DATA_W
) (
  input  bcs_state_e        state,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic              cur_write,
  input  logic              cur_mem,
  input  logic              cur_bhe,
  input  logic [ST_W-1:0]   cur_stat,
  input  logic [DATA_W-1:0] cur_wdata,
  output logic              addr_strobe,
  output logic              rd_stb_n,
  output logic              wr_stb_n,
  output logic              xcvr_en_n,
  output logic              xcvr_dir_tx,
  output logic              space_mem,
  output logic              hi_byte_n,
  output logic [ADDR_W-1:0] mux_out,
  output logic              mux_oe_lo,
  output logic              mux_oe_hi,
  output logic              rsp_done
);
  logic in_t1, in_data, in_cycle;

  assign in_t1    = (state == ST_T1);
  assign in_data  = (state == ST_T2) || (state == ST_T3) || (state == ST_TW);
  assign in_cycle = (state != ST_IDLE);

  always_comb begin
    addr_strobe = in_t1;
    rd_stb_n    = !(in_data && !cur_write);
    wr_stb_n    = !(in_data && cur_write);
    xcvr_en_n   = !in_data;
    xcvr_dir_tx = cur_write;
    space_mem   = cur_mem;
    hi_byte_n   = in_t1 ? !cur_bhe : 1'b1;
    mux_oe_hi   = in_cycle;
    mux_oe_lo   = in_t1 || (in_data && cur_write);
    rsp_done    = (state == ST_T4);
    if (in_t1) mux_out = cur_addr;
    else       mux_out = {cur_stat, (cur_write ? cur_wdata : {DATA_W{1'b0}})};
  end
endmodule

// File: rtl/bcs_rdcap.sv
module bcs_rdcap #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] mux_in,
  output logic [DATA_W-1:0] rsp_rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rsp_rdata <= '0;
    else if (cap_en) rsp_rdata <= mux_in;
  end
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bcs_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int DATA_W     = 16,
  parameter int RST_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     arst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic                     req_write,
  input  logic                     req_mem,
  input  logic                     req_bhe,
  input  logic [ADDR_W-DATA_W-1:0] req_stat,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic                     bus_rdy,
  output logic                     addr_strobe,
  output logic                     rd_stb_n,
  output logic                     wr_stb_n,
  output logic                     xcvr_en_n,
  output logic                     xcvr_dir_tx,
  output logic                     space_mem,
  output logic                     hi_byte_n,
  output logic [ADDR_W-1:0]        mux_out,
  output logic                     mux_oe_lo,
  output logic                     mux_oe_hi,
  input  logic [DATA_W-1:0]        mux_in,
  output logic                     rsp_done,
  output logic [DATA_W-1:0]        rsp_rdata
);
  localparam int ST_W = ADDR_W - DATA_W;

  logic              rst_n;
  bcs_state_e        state;
  logic              last_edge;
  logic [ADDR_W-1:0] cur_addr;
  logic              cur_write, cur_mem, cur_bhe;
  logic [ST_W-1:0]   cur_stat;
  logic [DATA_W-1:0] cur_wdata;

  bcs_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .arst_n(arst_n), .rst_n(rst_n)
  );

  bcs_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ST_W(ST_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_mem(req_mem),
    .req_bhe(req_bhe), .req_stat(req_stat), .req_wdata(req_wdata),
    .bus_rdy(bus_rdy), .state(state), .last_edge(last_edge),
    .cur_addr(cur_addr), .cur_write(cur_write), .cur_mem(cur_mem),
    .cur_bhe(cur_bhe), .cur_stat(cur_stat), .cur_wdata(cur_wdata)
  );

  bcs_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ST_W(ST_W)) u_drv (
    .state(state), .cur_addr(cur_addr), .cur_write(cur_write),
    .cur_mem(cur_mem), .cur_bhe(cur_bhe), .cur_stat(cur_stat),
    .cur_wdata(cur_wdata),
    .addr_strobe(addr_strobe), .rd_stb_n(rd_stb_n), .wr_stb_n(wr_stb_n),
    .xcvr_en_n(xcvr_en_n), .xcvr_dir_tx(xcvr_dir_tx), .space_mem(space_mem),
    .hi_byte_n(hi_byte_n), .mux_out(mux_out), .mux_oe_lo(mux_oe_lo),
    .mux_oe_hi(mux_oe_hi), .rsp_done(rsp_done)
  );

  bcs_rdcap #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap_en(last_edge && !cur_write),
    .mux_in(mux_in), .rsp_rdata(rsp_rdata)
  );
endmodule

// File: rtl/bcs_chk.sv
module bcs_chk (
  input logic clk,
  input logic arst_n,
  input logic req_valid,
  input logic addr_strobe,
  input logic rd_stb_n,
  input logic wr_stb_n,
  input logic xcvr_en_n,
  input logic mux_oe_lo,
  input logic mux_oe_hi,
  input logic rsp_done
);
  p_strobe_excl_r1: assert property (@(posedge clk) disable iff (!arst_n)
    !(!rd_stb_n && !wr_stb_n));

  p_rd_min_len_r1: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(rd_stb_n) |=> !rd_stb_n);

  p_ale_single_r2: assert property (@(posedge clk) disable iff (!arst_n)
    addr_strobe |=> !addr_strobe);

  p_ale_setup_r3: assert property (@(posedge clk) disable iff (!arst_n)
    addr_strobe |-> (xcvr_en_n && rd_stb_n && wr_stb_n && mux_oe_lo && mux_oe_hi));

  p_read_release_r4: assert property (@(posedge clk) disable iff (!arst_n)
    !rd_stb_n |-> (!mux_oe_lo && !xcvr_en_n));

  p_write_drive_r5: assert property (@(posedge clk) disable iff (!arst_n)
    !wr_stb_n |-> (mux_oe_lo && !xcvr_en_n));

  p_end_state_r8: assert property (@(posedge clk) disable iff (!arst_n)
    rsp_done |-> (rd_stb_n && wr_stb_n && xcvr_en_n && !mux_oe_lo));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!arst_n)
    rsp_done |=> !rsp_done);

  p_chain_r10: assert property (@(posedge clk) disable iff (!arst_n)
    (rsp_done && req_valid) |=> addr_strobe);
endmodule

bind bus_cycle_seq bcs_chk u_chk (
  .clk(clk), .arst_n(arst_n), .req_valid(req_valid),
  .addr_strobe(addr_strobe), .rd_stb_n(rd_stb_n), .wr_stb_n(wr_stb_n),
  .xcvr_en_n(xcvr_en_n), .mux_oe_lo(mux_oe_lo), .mux_oe_hi(mux_oe_hi),
  .rsp_done(rsp_done)
);

// File: tb/tb_bus_cycle_seq.sv
module tb_bus_cycle_seq;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam int SW = AW - DW;

  logic clk = 1'b0;
  logic arst_n;
  logic req_valid, req_ready, req_write, req_mem, req_bhe, bus_rdy;
  logic [AW-1:0] req_addr;
  logic [SW-1:0] req_stat;
  logic [DW-1:0] req_wdata, mux_in, rsp_rdata;
  logic addr_strobe, rd_stb_n, wr_stb_n, xcvr_en_n, xcvr_dir_tx, space_mem, hi_byte_n;
  logic [AW-1:0] mux_out;
  logic mux_oe_lo, mux_oe_hi, rsp_done;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  bus_cycle_seq #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .arst_n(arst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_mem(req_mem),
    .req_bhe(req_bhe), .req_stat(req_stat), .req_wdata(req_wdata),
    .bus_rdy(bus_rdy), .addr_strobe(addr_strobe), .rd_stb_n(rd_stb_n),
    .wr_stb_n(wr_stb_n), .xcvr_en_n(xcvr_en_n), .xcvr_dir_tx(xcvr_dir_tx),
    .space_mem(space_mem), .hi_byte_n(hi_byte_n), .mux_out(mux_out),
    .mux_oe_lo(mux_oe_lo), .mux_oe_hi(mux_oe_hi), .mux_in(mux_in),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata)
  );

  // Transfer descriptor fields: current and next
  logic [AW-1:0] c_addr, n_addr;
  logic          c_wr, c_mem, c_bhe, n_wr, n_mem, n_bhe;
  logic [SW-1:0] c_stat, n_stat;
  logic [DW-1:0] c_wd, n_wd;

  function automatic logic [AW-1:0] exp_data_phase(input logic [SW-1:0] s,
                                                   input logic [DW-1:0] d);
    return {s, d};
  endfunction

  function automatic logic exp_dir(input logic w);
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    chk(addr_strobe == 1'b0, req, "idle strobe", 32'(addr_strobe), 0);
    chk(rd_stb_n && wr_stb_n, req, "idle rd/wr", {30'd0, rd_stb_n, wr_stb_n}, 3);
    chk(!mux_oe_lo && !mux_oe_hi, req, "idle oe", {30'd0, mux_oe_lo, mux_oe_hi}, 0);
    chk(rsp_done == 1'b0, req, "idle done", 32'(rsp_done), 0);
    chk(xcvr_en_n == 1'b1, req, "idle xcvr_en_n", 32'(xcvr_en_n), 1);
    chk(req_ready == 1'b1, req, "idle req_ready", 32'(req_ready), 1);
  endtask

  task automatic issue_next();
    req_valid = 1'b1;
    req_addr  = n_addr;  req_write = n_wr;  req_mem = n_mem;
    req_bhe   = n_bhe;   req_stat  = n_stat; req_wdata = n_wd;
    chk(req_ready == 1'b1, "R10", "req_ready at issue", 32'(req_ready), 1);
  endtask

  task automatic pick_next();
    n_addr = AW'($urandom);
    n_wr   = 1'($urandom);
    n_mem  = 1'($urandom);
    n_bhe  = 1'($urandom);
    n_stat = SW'($urandom);
    n_wd   = DW'($urandom);
  endtask

  task automatic take_next();
    c_addr = n_addr; c_wr = n_wr; c_mem = n_mem;
    c_bhe = n_bhe; c_stat = n_stat; c_wd = n_wd;
  endtask

  task automatic check_mid(input string req);
    chk(addr_strobe == 1'b0, req, "strobe low", 32'(addr_strobe), 0);
    chk(xcvr_en_n == 1'b0, "R3", "xcvr_en_n low mid", 32'(xcvr_en_n), 0);
    chk(xcvr_dir_tx == exp_dir(c_wr), "R3", "dir", 32'(xcvr_dir_tx), 32'(c_wr));
    chk(mux_oe_hi && hi_byte_n, "R6", "hi oe / status bit", {30'd0, mux_oe_hi, hi_byte_n}, 3);
    chk(mux_out[AW-1:DW] == c_stat, "R6", "status lines", 32'(mux_out[AW-1:DW]), 32'(c_stat));
    if (c_wr) begin
      chk(!wr_stb_n && rd_stb_n, "R5", "write strobes", {30'd0, rd_stb_n, wr_stb_n}, 2);
      chk(mux_oe_lo && mux_out == exp_data_phase(c_stat, c_wd), "R5", "write data",
          32'(mux_out), 32'(exp_data_phase(c_stat, c_wd)));
    end else begin
      chk(!rd_stb_n && wr_stb_n, "R4", "read strobes", {30'd0, rd_stb_n, wr_stb_n}, 1);
      chk(mux_oe_lo == 1'b0, "R4", "low lines released", 32'(mux_oe_lo), 0);
    end
    chk(req_ready == 1'b0, "R10", "req_ready busy", 32'(req_ready), 0);
  endtask

  // Entered at the negedge inside T1; returns at the negedge after T4
  task automatic run_xfer(input int nw, input bit chain);
    logic [DW-1:0] rdv;
    rdv = DW'($urandom);
    req_valid = 1'b0;
    // T1
    chk(addr_strobe == 1'b1, "R2", "T1 strobe", 32'(addr_strobe), 1);
    chk(mux_out == c_addr && mux_oe_lo && mux_oe_hi, "R2", "T1 address",
        32'(mux_out), 32'(c_addr));
    chk(hi_byte_n == !c_bhe, "R2", "T1 hi_byte_n", 32'(hi_byte_n), 32'(!c_bhe));
    chk(space_mem == c_mem, "R2", "T1 space", 32'(space_mem), 32'(c_mem));
    chk(rd_stb_n && wr_stb_n, "R2", "T1 strobes idle", {30'd0, rd_stb_n, wr_stb_n}, 3);
    chk(xcvr_en_n == 1'b1, "R3", "T1 xcvr_en_n", 32'(xcvr_en_n), 1);
    chk(xcvr_dir_tx == exp_dir(c_wr), "R3", "T1 dir", 32'(xcvr_dir_tx), 32'(c_wr));
    @(negedge clk); // T2
    check_mid("R1");
    bus_rdy = 1'($urandom); // not sampled in T2 (R7)
    mux_in  = DW'($urandom);
    @(negedge clk); // T3
    check_mid("R1");
    bus_rdy = (nw == 0);
    mux_in  = (nw == 0) ? rdv : DW'($urandom);
    for (int k = 0; k < nw; k++) begin
      @(negedge clk); // wait state
      check_mid("R7");
      bus_rdy = (k == nw - 1);
      mux_in  = (k == nw - 1) ? rdv : DW'($urandom);
    end
    @(negedge clk); // T4
    chk(rsp_done == 1'b1, "R8", "done in T4", 32'(rsp_done), 1);
    chk(rd_stb_n && wr_stb_n && xcvr_en_n, "R8", "T4 strobes high",
        {29'd0, rd_stb_n, wr_stb_n, xcvr_en_n}, 7);
    chk(mux_oe_lo == 1'b0 && mux_oe_hi, "R6", "T4 oe", {30'd0, mux_oe_lo, mux_oe_hi}, 1);
    if (!c_wr) chk(rsp_rdata == rdv, "R8", "read data", 32'(rsp_rdata), 32'(rdv));
    chk(req_ready == 1'b1, "R10", "req_ready in T4", 32'(req_ready), 1);
    mux_in  = DW'($urandom);
    bus_rdy = 1'($urandom);
    if (chain) issue_next();
    @(negedge clk);
    if (chain) begin
      chk(addr_strobe == 1'b1, "R10", "back-to-back T1", 32'(addr_strobe), 1);
    end else begin
      check_idle("R9");
      chk(rsp_done == 1'b0, "R8", "done one cycle", 32'(rsp_done), 0);
    end
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0b05));
    arst_n = 1'b0; req_valid = 1'b0; bus_rdy = 1'b1; mux_in = '0;
    req_addr = '0; req_write = 1'b0; req_mem = 1'b0; req_bhe = 1'b0;
    req_stat = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    check_idle("R11");
    chk(xcvr_dir_tx == 1'b0 && rsp_rdata == '0, "R11", "reset dir/rdata",
        {15'd0, xcvr_dir_tx, rsp_rdata}, 0);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_idle("R11");

    // Directed: write with no waits (R1), read with three waits (R7), chained read
    n_addr = 20'hABCDE; n_wr = 1'b1; n_mem = 1'b1; n_bhe = 1'b1; n_stat = 4'h9; n_wd = 16'h1234;
    issue_next(); take_next(); @(negedge clk);
    run_xfer(0, 1'b0);
    n_addr = 20'h00001; n_wr = 1'b0; n_mem = 1'b0; n_bhe = 1'b0; n_stat = 4'h6; n_wd = 16'hFFFF;
    issue_next(); take_next(); @(negedge clk);
    n_addr = 20'hFFFFF; n_wr = 1'b0; n_mem = 1'b1; n_bhe = 1'b1; n_stat = 4'hF; n_wd = 16'h0;
    run_xfer(3, 1'b1);
    take_next();
    run_xfer(0, 1'b0);

    // Random transfers
    pick_next(); issue_next(); take_next(); @(negedge clk);
    for (int i = 0; i < 60; i++) begin
      bit chain;
      int nw;
      pick_next();
      chain = (i < 59) && ($urandom % 2 == 1);
      nw = int'($urandom % 4);
      run_xfer(nw, chain);
      if (!chain && i < 59) begin
        if ($urandom % 2 == 1) begin
          @(negedge clk);
          check_idle("R9");
        end
        issue_next(); @(negedge clk);
      end
      take_next();
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule